// File: doc/BRIEF.md
# Freezing Event Counter Box

This block gathers performance events into four 44-bit counters. Each counter has its own control word. The control word picks one event from a bank of per-cycle increment inputs, enables counting, and enables overflow reporting. On every clock with counting active, each enabled counter adds the 5-bit increment of its chosen event. Some event classes are allowed only on certain counters. A counter that picks a class outside its allowed set stays still.

When a counter with overflow reporting enabled wraps, three things happen. Its bit in the status word is set, a one-cycle pulse goes out to the global controller, and the whole box freezes. The freeze ends only after software has cleared the status with write-one-to-clear and the global enable input has been dropped and raised again. Software uses a plain single-cycle register port. Reads are combinational. Counter values can be preloaded while the box is not counting.

Top module: `pmon_freeze_box`

## Requirements
- R1: After reset all four control words, all four counters and the status word read zero, and `ovf_pulse` is low.
- R2: Register map on `reg_addr`: 0..3 are control words with select in bits [7:0], enable in bit 8 and overflow-report enable in bit 9; 4..7 are counters 0..3; 8 is status, where bit i belongs to counter i; other addresses read zero. Writes take effect at the clock edge and reads are combinational.
- R3: When counting is active (`glb_en` high and the box not frozen), an enabled counter adds, at each clock edge, the increment for its selected event, modulo 2^44. Event k's increment is `ev_inc[5k+4:5k]`.
- R4: Select codes 0..7 count on any counter. Codes 8..11 count only on counters 2 and 3. Codes 12..15 count only on counter 0. Codes 16 and above never count. A disallowed selection leaves the counter unchanged.
- R5: A counter whose enable bit is clear does not change while counting is active.
- R6: When a counter with overflow-report enable set wraps past 2^44-1, its status bit becomes 1 and the box freezes. All counters hold their values from the next edge on.
- R7: A wrap on a counter with overflow-report enable clear leaves the wrapped value, sets no status bit and causes no freeze.
- R8: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: A frozen box resumes only after the status word is all zero and `glb_en` has been seen low on a clock edge. Counting then restarts once `glb_en` is high.
- R10: A counter write takes effect only while counting is not active. While counting is active the write is ignored and the counter advances as usual.
- R11: `ovf_pulse` is high for exactly one cycle, in the cycle after a status bit goes from 0 to 1. Several counters wrapping on the same edge give a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global counting enable from the controller |
| ev_inc | input | NUM_EV*INC_W | Per-event increment values, event k in slice k |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational |
| ovf_pulse | output | 1 | One-cycle overflow notice to the global controller |

## Verification
The hardest state to reach from the ports is a wrap of a 44-bit counter. Counting there from zero is out of reach, so the bench first parks `glb_en` low and preloads each counter a few steps below its maximum. It then lets single edges through and watches the pulse, the status word and the frozen values edge by edge. From that frozen state, the bench clears status with `glb_en` still high to show the freeze persists. It then drops and raises `glb_en` to show counting resumes. It also makes two counters wrap on the same edge to check that only one pulse is sent.

// File: rtl/pmon_freeze_box.sv
module pmon_freeze_box #(
  parameter int CTR_W    = 44,
  parameter int INC_W    = 5,
  parameter int EV_W     = 8,
  parameter int NUM_EV   = 16,
  parameter int RING_LO  = 8,
  parameter int OCC_LO   = 12,
  parameter int CLASS_SZ = 4,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic [NUM_EV*INC_W-1:0] ev_inc,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic                    ovf_pulse
);
  localparam int NCTR   = 4;
  localparam int CTL_W  = EV_W + 2;
  localparam int EN_B   = EV_W;
  localparam int OVE_B  = EV_W + 1;
  localparam int IDX_W  = $clog2(NUM_EV);
  localparam logic [EV_W-1:0] EV_LIM  = EV_W'(NUM_EV);
  localparam logic [EV_W-1:0] RING_A  = EV_W'(RING_LO);
  localparam logic [EV_W-1:0] RING_B  = EV_W'(RING_LO + CLASS_SZ);
  localparam logic [EV_W-1:0] OCC_A   = EV_W'(OCC_LO);
  localparam logic [EV_W-1:0] OCC_B   = EV_W'(OCC_LO + CLASS_SZ);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(2 * NCTR);

  logic [NCTR-1:0][CTL_W-1:0] ctl_q;
  logic [NCTR-1:0][CTR_W-1:0] ctr_q;
  logic [NCTR-1:0] stat_q, wrap, ove, en_v, set_v, clr_v;
  logic halt_q, run;

  assign run   = glb_en & ~halt_q;
  assign set_v = wrap & ove;
  assign clr_v = (reg_wr && reg_addr == STAT_A) ? reg_wdata[NCTR-1:0] : '0;

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    logic [EV_W-1:0]  sel;
    logic [IDX_W-1:0] idx;
    logic             legal;
    logic [INC_W-1:0] inc;
    logic [CTR_W:0]   sum;

    assign sel    = ctl_q[g][EV_W-1:0];
    assign idx    = sel[IDX_W-1:0];
    assign en_v[g] = ctl_q[g][EN_B];
    assign ove[g]  = ctl_q[g][OVE_B];

    always_comb begin
      if (sel >= EV_LIM)                      legal = 1'b0;
      else if (sel >= OCC_A && sel < OCC_B)   legal = (g == 0);
      else if (sel >= RING_A && sel < RING_B) legal = (g >= 2);
      else                                    legal = 1'b1;
    end

    assign inc     = legal ? ev_inc[idx*INC_W +: INC_W] : '0;
    assign sum     = {1'b0, ctr_q[g]} + (CTR_W+1)'(inc);
    assign wrap[g] = run & en_v[g] & sum[CTR_W];

    always_ff @(posedge clk) begin
      if (!rst_n)
        ctl_q[g] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(g))
        ctl_q[g] <= reg_wdata[CTL_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        ctr_q[g] <= '0;
      else if (!run && reg_wr && reg_addr == ADDR_W'(NCTR + g))
        ctr_q[g] <= reg_wdata[CTR_W-1:0];
      else if (run && en_v[g])
        ctr_q[g] <= sum[CTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      ovf_pulse <= 1'b0;
      halt_q    <= 1'b0;
    end else begin
      stat_q    <= (stat_q & ~clr_v) | set_v;
      ovf_pulse <= |(set_v & ~stat_q);
      if (|set_v)
        halt_q <= 1'b1;
      else if (stat_q == '0 && !glb_en)
        halt_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCTR; i++) begin
      if (reg_addr == ADDR_W'(i))        reg_rdata = DATA_W'(ctl_q[i]);
      if (reg_addr == ADDR_W'(NCTR + i)) reg_rdata = DATA_W'(ctr_q[i]);
    end
    if (reg_addr == STAT_A) reg_rdata = DATA_W'(stat_q);
  end
endmodule

// File: rtl/pmon_freeze_box_chk.sv
module pmon_freeze_box_chk #(
  parameter int CTR_W = 44
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  glb_en,
  input logic                  reg_wr,
  input logic                  halt_q,
  input logic                  ovf_pulse,
  input logic [3:0]            stat_q,
  input logic [3:0]            en_v,
  input logic [3:0][CTR_W-1:0] ctr_q
);
  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  p_pulse_new_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ((stat_q & ~$past(stat_q)) != 4'b0));

  p_new_bit_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) != 4'b0) |-> halt_q);

  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !reg_wr) |=> $stable(ctr_q));

  p_resume_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_q) |-> (stat_q == 4'b0 && !$past(glb_en)));

  for (genvar i = 0; i < 4; i++) begin : g_en
    p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_v[i] && !reg_wr) |=> $stable(ctr_q[i]));
  end
endmodule

bind pmon_freeze_box pmon_freeze_box_chk #(.CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .reg_wr(reg_wr), .halt_q(halt_q),
  .ovf_pulse(ovf_pulse), .stat_q(stat_q), .en_v(en_v), .ctr_q(ctr_q)
);

// File: tb/pmon_freeze_box_tb.sv
module pmon_freeze_box_tb_top;
  localparam int CLK_P = 10;
  localparam logic [63:0] MAXV = (64'd1 << 44) - 64'd1;

  logic clk = 1'b0, rst_n = 1'b0, glb_en = 1'b0, reg_wr = 1'b0;
  logic [79:0] ev_inc;
  logic [3:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata, rv;
  logic        ovf_pulse;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  pmon_freeze_box dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ev_inc(ev_inc), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_pulse(ovf_pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] inc_of(input int k);
    return 64'((k * 3 + 1) % 32);
  endfunction

  function automatic bit legal(input int c, input int k);
    if (k >= 16) return 0;
    if (k >= 12) return c == 0;
    if (k >= 8)  return c >= 2;
    return 1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = reg_rdata;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    glb_en = 1'b1;
    repeat (n) @(negedge clk);
    glb_en = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) ev_inc[k*5 +: 5] = 5'(inc_of(k));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 9; a++) begin
      rd(a, rv); chk("R1 reset read", rv, 64'd0);
    end
    chk("R1 pulse low", {63'd0, ovf_pulse}, 64'd0);
    rd(12, rv); chk("R2 unmapped read", rv, 64'd0);

    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 18; k++) begin
        wr(c, 64'(k) | 64'h100);
        wr(4 + c, 64'd0);
        run(3);
        rd(4 + c, rv);
        chk("R4 class sweep", rv, legal(c, k) ? 3 * inc_of(k) : 64'd0);
      end
      rd(c, rv); chk("R2 ctl readback", rv, 64'h111);
      wr(c, 64'd0);
    end

    wr(1, 64'd1); wr(5, 64'd5); run(4);
    rd(5, rv); chk("R5 disabled counter holds", rv, 64'd5);

    wr(1, 64'h101); wr(5, 64'd0);
    @(negedge clk);
    glb_en = 1'b1; reg_wr = 1'b1; reg_addr = 4'd5; reg_wdata = 64'd999;
    @(negedge clk);
    glb_en = 1'b0; reg_wr = 1'b0;
    rd(5, rv); chk("R10 write ignored while counting", rv, 64'd4);

    wr(5, MAXV - 1); run(2);
    rd(5, rv); chk("R7 wrap without report", rv, 64'd6);
    rd(8, rv); chk("R7 no status", rv, 64'd0);
    run(1);
    rd(5, rv); chk("R7 no freeze", rv, 64'd10);
    wr(1, 64'd0);

    wr(0, 64'h301); wr(4, MAXV - 2);
    @(negedge clk); glb_en = 1'b1;
    @(negedge clk);
    chk("R11 pulse after wrap", {63'd0, ovf_pulse}, 64'd1);
    reg_addr = 4'd8; #1 chk("R6 status set", reg_rdata, 64'd1);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R11 pulse one cycle", {63'd0, ovf_pulse}, 64'd0);
    end
    rd(4, rv); chk("R6 frozen value", rv, 64'd1);

    wr(8, 64'd0);
    rd(8, rv); chk("R8 zero write keeps bit", rv, 64'd1);
    wr(8, 64'd1);
    rd(8, rv); chk("R8 one write clears", rv, 64'd0);
    repeat (3) @(negedge clk);
    rd(4, rv); chk("R9 still frozen with glb_en high", rv, 64'd1);
    wr(4, 64'd20);
    rd(4, rv); chk("R10 write accepted while frozen", rv, 64'd20);
    glb_en = 1'b0;
    @(negedge clk);
    run(3);
    rd(4, rv); chk("R9 resume after toggle", rv, 64'd32);
    wr(0, 64'd0);

    wr(2, 64'h301); wr(3, 64'h301);
    wr(6, MAXV - 3); wr(7, MAXV - 3);
    @(negedge clk); glb_en = 1'b1;
    @(negedge clk);
    chk("R11 single pulse for double wrap", {63'd0, ovf_pulse}, 64'd1);
    @(negedge clk);
    chk("R11 pulse drops", {63'd0, ovf_pulse}, 64'd0);
    glb_en = 1'b0;
    rd(8, rv); chk("R6 both status bits", rv, 64'hC);
    rd(6, rv); chk("R3 wrap modulo", rv, 64'd0);
    wr(8, 64'h4);
    rd(8, rv); chk("R8 partial clear", rv, 64'h8);
    run(2);
    rd(7, rv); chk("R9 frozen while status nonzero", rv, 64'd0);
    wr(8, 64'h8);
    @(negedge clk);
    run(2);
    rd(7, rv); chk("R3 counting after re-arm", rv, 64'd8);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule